// File: doc/BRIEF.md
# Omega Self-Routing Packet Switch

This block connects a set of input ports to an equal number of output ports through a blocking multistage network of 2x2 switching elements. The default is eight ports, three stages and twelve elements. Every input presents a valid flag, a destination port number and a payload word. Ahead of every stage the lanes are reordered by the same perfect shuffle: the lane number is rotated left by one bit. Each element then steers each packet with one bit of its destination. Stage 0 uses the most significant bit and the last stage uses the least significant bit. A bit value of 0 picks the element's upper output and 1 picks the lower output.

The whole pass through the network is combinational and is registered once at the outputs. Two packets can reach one element and ask for the same output of that element. When that happens, the packet on the upper input gets the link. The other packet is discarded, and a per-input blocked flag reports the loss in the same cycle that the surviving packets appear. Each delivered packet carries the number of its source port, so a user can match deliveries against the permutation that was requested. The block has no internal buffering and does not retry a lost packet.

Top module: `omega_selfroute_switch`

## Requirements
- R1: After reset, every output valid bit and every blocked flag is 0.
- R2: A packet that is not blocked appears one clock edge after it is presented, on the output port whose number equals its destination. The destination of input i is `inDst[3i+2:3i]`. Output port p is bit p of `outValid`.
- R3: A delivered packet carries its payload (`outData[8p+7:8p]`, taken from `inData[8i+7:8i]`) and its source port number (`outSrc[3p+2:3p]`).
- R4: Stage k steers on destination bit (2-k), so the MSB is used first. A bit value of 0 leaves an element on its upper output and 1 on its lower output. The lanes are shuffled by a rotate-left of the lane number ahead of every stage. As a result, the paths for 1→3 and 5→6 do not collide.
- R5: When two packets at one element ask for the same output, the packet on the upper input keeps the link. The packet on the lower input is discarded, and bit i of `blocked` is 1 for its source i in the same cycle that the results appear.
- R6: An input whose valid flag is 0 takes part in no arbitration and never appears at an output. When no input is valid, the following cycle shows no output valid.
- R7: Every valid input is either delivered or blocked, never both. The number of set `outValid` bits plus the number of set `blocked` bits equals the number of valid inputs on the previous edge.
- R8: Packets with different destinations can still block each other. For 0→0 with 4→2, input 4 is lost. For the bit-reversal permutation, inputs 4 to 7 are lost.
- R9: The identity permutation and the cyclic shift i→(i+1) mod 8 pass with no packet blocked.
- R10: When all inputs target one port, exactly one packet survives, and it is the packet from input 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| inValid | input | NUM_PORTS | Per-input packet valid |
| inDst | input | NUM_PORTS*log2(NUM_PORTS) | Per-input destination port, packed by input |
| inData | input | NUM_PORTS*DATA_W | Per-input payload, packed by input |
| outValid | output | NUM_PORTS | Registered per-output packet valid |
| outData | output | NUM_PORTS*DATA_W | Registered per-output payload |
| outSrc | output | NUM_PORTS*log2(NUM_PORTS) | Registered source port of each delivered packet |
| blocked | output | NUM_PORTS | Registered per-input flag: the packet was discarded at a link conflict |

## Verification
The identity and unit-shift permutations load every element with a full pair that never clashes, so a wrong shuffle or a wrong choice of steering bit shows up as misplaced sources. The sparse pairs 1→3 with 5→6, 0→0 with 4→2, and 0→4 with 4→5 separate clean passage from clashes on the upper and on the lower output of a single element. The pair with one input invalid confirms that an idle lane does not take part in arbitration. The bit-reversal and all-to-one patterns create clashes in several stages at once. Because exactly one known packet survives the all-to-one pattern, these patterns expose a wrong winner rule or a blocked flag charged to the wrong source.

// File: rtl/omega_pkg.sv
package omega_pkg;

  // Steering strobes for one 2x2 element, produced by the route control
  // and consumed by the payload datapath.
  typedef struct packed {
    logic upFromLo;  // upper output takes the lower input
    logic loFromLo;  // lower output takes the lower input
    logic upVld;     // upper output carries a packet
    logic loVld;     // lower output carries a packet
  } elemSel_t;

endpackage

// File: rtl/omega_route_ctl.sv
module omega_route_ctl
  import omega_pkg::*;
#(
  parameter int NUM_PORTS = 8
) (
  input  logic                                   clk,
  input  logic                                   rst_n,
  input  logic [NUM_PORTS-1:0]                   inValid,
  input  logic [NUM_PORTS*$clog2(NUM_PORTS)-1:0] inDst,
  output elemSel_t [$clog2(NUM_PORTS)*(NUM_PORTS/2)-1:0] selVec,
  output logic [NUM_PORTS-1:0]                   blocked
);

  localparam int L = $clog2(NUM_PORTS);
  localparam int S = L;
  localparam int E = NUM_PORTS / 2;

  function automatic logic [L-1:0] rotl(input logic [L-1:0] a);
    return {a[L-2:0], a[L-1]};
  endfunction

  // header state at the input of each stage, before the shuffle
  logic         laneV [S][NUM_PORTS];
  logic [L-1:0] laneD [S][NUM_PORTS];
  logic [L-1:0] laneO [S][NUM_PORTS];
  // the same state after the shuffle
  logic         shV   [S][NUM_PORTS];
  logic [L-1:0] shD   [S][NUM_PORTS];
  logic [L-1:0] shO   [S][NUM_PORTS];
  logic [NUM_PORTS-1:0] blkNext;

  always_comb begin
    blkNext = '0;
    selVec  = '0;
    for (int a = 0; a < NUM_PORTS; a++) begin
      laneV[0][a] = inValid[a];
      laneD[0][a] = inDst[a*L +: L];
      laneO[0][a] = L'(a);
    end
    for (int s = 0; s < S; s++) begin
      for (int a = 0; a < NUM_PORTS; a++) begin
        shV[s][rotl(L'(a))] = laneV[s][a];
        shD[s][rotl(L'(a))] = laneD[s][a];
        shO[s][rotl(L'(a))] = laneO[s][a];
      end
      for (int e = 0; e < E; e++) begin : g_elem
        logic uUp, uLo, lUp, lLo, clash;
        uUp   = shV[s][2*e]   & ~shD[s][2*e][L-1-s];
        uLo   = shV[s][2*e]   &  shD[s][2*e][L-1-s];
        lUp   = shV[s][2*e+1] & ~shD[s][2*e+1][L-1-s];
        lLo   = shV[s][2*e+1] &  shD[s][2*e+1][L-1-s];
        clash = (uUp & lUp) | (uLo & lLo);
        selVec[s*E+e].upFromLo = ~uUp & lUp;
        selVec[s*E+e].loFromLo = ~uLo & lLo;
        selVec[s*E+e].upVld    = uUp | lUp;
        selVec[s*E+e].loVld    = uLo | lLo;
        if (clash) blkNext[shO[s][2*e+1]] = 1'b1;  // upper input wins
        if (s < S-1) begin
          laneV[s+1][2*e]   = uUp | lUp;
          laneD[s+1][2*e]   = uUp ? shD[s][2*e] : shD[s][2*e+1];
          laneO[s+1][2*e]   = uUp ? shO[s][2*e] : shO[s][2*e+1];
          laneV[s+1][2*e+1] = uLo | lLo;
          laneD[s+1][2*e+1] = uLo ? shD[s][2*e] : shD[s][2*e+1];
          laneO[s+1][2*e+1] = uLo ? shO[s][2*e] : shO[s][2*e+1];
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) blocked <= '0;
    else        blocked <= blkNext;
  end

  // a lone packet has nobody to collide with
  p_lone_free_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ($countones(inValid) <= 1) |=> (blocked == '0));

endmodule

// File: rtl/omega_payload_path.sv
module omega_payload_path
  import omega_pkg::*;
#(
  parameter int NUM_PORTS = 8,
  parameter int DATA_W    = 8
) (
  input  logic                                   clk,
  input  logic                                   rst_n,
  input  logic [NUM_PORTS*DATA_W-1:0]            inData,
  input  elemSel_t [$clog2(NUM_PORTS)*(NUM_PORTS/2)-1:0] selVec,
  output logic [NUM_PORTS-1:0]                   outValid,
  output logic [NUM_PORTS*DATA_W-1:0]            outData,
  output logic [NUM_PORTS*$clog2(NUM_PORTS)-1:0] outSrc
);

  localparam int L = $clog2(NUM_PORTS);
  localparam int S = L;
  localparam int E = NUM_PORTS / 2;

  function automatic logic [L-1:0] rotl(input logic [L-1:0] a);
    return {a[L-2:0], a[L-1]};
  endfunction

  logic [DATA_W-1:0] laneDat [S][NUM_PORTS];
  logic [L-1:0]      laneSrc [S][NUM_PORTS];
  logic [DATA_W-1:0] shDat   [S][NUM_PORTS];
  logic [L-1:0]      shSrc   [S][NUM_PORTS];
  logic [NUM_PORTS-1:0]          finV;
  logic [NUM_PORTS*DATA_W-1:0]   finDat;
  logic [NUM_PORTS*L-1:0]        finSrc;

  always_comb begin
    finV   = '0;
    finDat = '0;
    finSrc = '0;
    for (int a = 0; a < NUM_PORTS; a++) begin
      laneDat[0][a] = inData[a*DATA_W +: DATA_W];
      laneSrc[0][a] = L'(a);
    end
    for (int s = 0; s < S; s++) begin
      for (int a = 0; a < NUM_PORTS; a++) begin
        shDat[s][rotl(L'(a))] = laneDat[s][a];
        shSrc[s][rotl(L'(a))] = laneSrc[s][a];
      end
      for (int e = 0; e < E; e++) begin : g_mux
        elemSel_t sel;
        logic [DATA_W-1:0] upD, loD;
        logic [L-1:0]      upS, loS;
        sel = selVec[s*E+e];
        upD = !sel.upVld ? '0 : (sel.upFromLo ? shDat[s][2*e+1] : shDat[s][2*e]);
        upS = !sel.upVld ? '0 : (sel.upFromLo ? shSrc[s][2*e+1] : shSrc[s][2*e]);
        loD = !sel.loVld ? '0 : (sel.loFromLo ? shDat[s][2*e+1] : shDat[s][2*e]);
        loS = !sel.loVld ? '0 : (sel.loFromLo ? shSrc[s][2*e+1] : shSrc[s][2*e]);
        if (s < S-1) begin
          laneDat[s+1][2*e]   = upD;
          laneSrc[s+1][2*e]   = upS;
          laneDat[s+1][2*e+1] = loD;
          laneSrc[s+1][2*e+1] = loS;
        end else begin
          finV[2*e]                           = sel.upVld;
          finV[2*e+1]                         = sel.loVld;
          finDat[(2*e)*DATA_W +: DATA_W]      = upD;
          finDat[(2*e+1)*DATA_W +: DATA_W]    = loD;
          finSrc[(2*e)*L +: L]                = upS;
          finSrc[(2*e+1)*L +: L]              = loS;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      outValid <= '0;
      outData  <= '0;
      outSrc   <= '0;
    end else begin
      outValid <= finV;
      outData  <= finDat;
      outSrc   <= finSrc;
    end
  end

endmodule

// File: rtl/omega_selfroute_switch.sv
module omega_selfroute_switch
  import omega_pkg::*;
#(
  parameter int NUM_PORTS = 8,
  parameter int DATA_W    = 8
) (
  input  logic                                   clk,
  input  logic                                   rst_n,
  input  logic [NUM_PORTS-1:0]                   inValid,
  input  logic [NUM_PORTS*$clog2(NUM_PORTS)-1:0] inDst,
  input  logic [NUM_PORTS*DATA_W-1:0]            inData,
  output logic [NUM_PORTS-1:0]                   outValid,
  output logic [NUM_PORTS*DATA_W-1:0]            outData,
  output logic [NUM_PORTS*$clog2(NUM_PORTS)-1:0] outSrc,
  output logic [NUM_PORTS-1:0]                   blocked
);

  localparam int L = $clog2(NUM_PORTS);
  localparam int E = NUM_PORTS / 2;

  elemSel_t [L*E-1:0] selVec;

  omega_route_ctl #(.NUM_PORTS(NUM_PORTS)) u_ctl (
    .clk     (clk),
    .rst_n   (rst_n),
    .inValid (inValid),
    .inDst   (inDst),
    .selVec  (selVec),
    .blocked (blocked)
  );

  omega_payload_path #(.NUM_PORTS(NUM_PORTS), .DATA_W(DATA_W)) u_path (
    .clk      (clk),
    .rst_n    (rst_n),
    .inData   (inData),
    .selVec   (selVec),
    .outValid (outValid),
    .outData  (outData),
    .outSrc   (outSrc)
  );

  p_conserve_r7: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ($countones(outValid) + $countones(blocked) == $countones($past(inValid))));

  p_idle_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (inValid == '0) |=> (outValid == '0));

  for (genvar i = 0; i < NUM_PORTS; i++) begin : g_blk_chk
    p_blk_had_valid_r5: assert property (@(posedge clk) disable iff (!rst_n)
      blocked[i] |-> $past(inValid[i]));
  end

endmodule

// File: tb/sim_omega_selfroute_switch.sv
`timescale 1ns/1ps
module sim_omega_selfroute_switch;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  inValid = '0;
  logic [23:0] inDst = '0;
  logic [63:0] inData = '0;
  logic [7:0]  outValid;
  logic [63:0] outData;
  logic [23:0] outSrc;
  logic [7:0]  blocked;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #2 clk = ~clk;

  omega_selfroute_switch #(.NUM_PORTS(8), .DATA_W(8)) u0 (
    .clk(clk), .rst_n(rst_n), .inValid(inValid), .inDst(inDst), .inData(inData),
    .outValid(outValid), .outData(outData), .outSrc(outSrc), .blocked(blocked)
  );

  function automatic logic [7:0] payload(int src, logic [7:0] salt);
    return 8'(src * 29) ^ salt;
  endfunction

  task automatic check(string req, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  // drive one pattern, let one edge register it, compare at the next negedge
  task automatic runCase(string req, logic [7:0] v, logic [23:0] d,
                         logic [7:0] expV, logic [23:0] expSrc, logic [7:0] expBlk,
                         logic [7:0] salt);
    @(negedge clk);
    inValid = v;
    inDst   = d;
    for (int i = 0; i < 8; i++) inData[i*8 +: 8] = payload(i, salt);
    @(negedge clk);
    check(req, "outValid", 32'(outValid), 32'(expV));
    check(req, "blocked", 32'(blocked), 32'(expBlk));
    for (int p = 0; p < 8; p++) begin
      if (expV[p]) begin
        check(req, $sformatf("src@%0d", p), 32'(outSrc[p*3 +: 3]), 32'(expSrc[p*3 +: 3]));
        check(req, $sformatf("data@%0d", p), 32'(outData[p*8 +: 8]),
              32'(payload(int'(expSrc[p*3 +: 3]), salt)));
      end
    end
  endtask

  function automatic logic [23:0] packDst(int d0, int d1, int d2, int d3,
                                          int d4, int d5, int d6, int d7);
    return {3'(d7), 3'(d6), 3'(d5), 3'(d4), 3'(d3), 3'(d2), 3'(d1), 3'(d0)};
  endfunction

  task automatic tReset();  // R1
    check("R1", "outValid after reset", 32'(outValid), 32'h0);
    check("R1", "blocked after reset", 32'(blocked), 32'h0);
  endtask

  task automatic tIdentity();  // R9, R2, R3
    runCase("R9", 8'hFF, packDst(0,1,2,3,4,5,6,7), 8'hFF,
            packDst(0,1,2,3,4,5,6,7), 8'h00, 8'h5A);
  endtask

  task automatic tShift();  // R9: i -> i+1, output p carries source p-1
    runCase("R9", 8'hFF, packDst(1,2,3,4,5,6,7,0), 8'hFF,
            packDst(7,0,1,2,3,4,5,6), 8'h00, 8'hC3);
  endtask

  task automatic tPaths();  // R4, R2: 1->3 and 5->6
    runCase("R4", 8'h22, packDst(0,3,0,0,0,6,0,0), 8'h48,
            packDst(0,0,0,1,0,0,5,0), 8'h00, 8'h11);
  endtask

  task automatic tDistinctClash();  // R8, R5: 0->0 and 4->2, input 4 loses
    runCase("R8", 8'h11, packDst(0,0,0,0,2,0,0,0), 8'h01,
            packDst(0,0,0,0,0,0,0,0), 8'h10, 8'h77);
  endtask

  task automatic tLowerClash();  // R5: 0->4 and 4->5 clash on the lower output
    runCase("R5", 8'h11, packDst(4,0,0,0,5,0,0,0), 8'h10,
            packDst(0,0,0,0,0,0,0,0), 8'h10, 8'h3C);
  endtask

  task automatic tInvalidIgnored();  // R6: idle input 0 does not stop input 4
    runCase("R6", 8'h10, packDst(0,0,0,0,2,0,0,0), 8'h04,
            packDst(0,0,4,0,0,0,0,0), 8'h00, 8'h99);
  endtask

  task automatic tBitReverse();  // R8, R7
    runCase("R8", 8'hFF, packDst(0,4,2,6,1,5,3,7), 8'h55,
            packDst(0,0,2,0,1,0,3,0), 8'hF0, 8'hE1);
  endtask

  task automatic tHotSpot();  // R10, R7
    runCase("R10", 8'hFF, packDst(5,5,5,5,5,5,5,5), 8'h20,
            packDst(0,0,0,0,0,0,0,0), 8'hFE, 8'h2D);
  endtask

  task automatic tIdle();  // R6
    runCase("R6", 8'h00, packDst(3,3,3,3,3,3,3,3), 8'h00,
            packDst(0,0,0,0,0,0,0,0), 8'h00, 8'h44);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    tReset();
    rst_n = 1'b1;
    @(negedge clk);
    tReset();
    tIdentity();
    tShift();
    tPaths();
    tDistinctClash();
    tLowerClash();
    tInvalidIgnored();
    tBitReverse();
    tHotSpot();
    tIdle();
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule